// File: doc/BRIEF.md
# Serial Configuration Port with Address Streaming

This block is a three-wire serial slave (serial clock, serial data, latch strobe) that fills a bank of byte-wide configuration registers. The three serial wires and an active-low enable come in asynchronously. They are brought into the system clock domain through flop chains, and their edges are detected there. Each transaction opens with a direction bit and a 15-bit register address, both sent most significant bit first. Data bytes follow, also most significant bit first. The rising edge of the latch strobe ends the transaction.

A write commits its data byte when the latch strobe rises. If the master keeps clocking past the first data byte without a latch strobe, each further byte goes to the next lower address. This lets a master load a run of registers while sending the address only once. A read uses the same frame layout. The addressed register is shifted out on the readback pin during the data phase. When clocking continues, the next lower register follows.

The serial side has no back-pressure. The slave takes one bit on every detected serial clock rise and can never stall the master. In return, the master must hold each serial clock and latch phase for at least three system clock periods. The register contents are presented as a plain parallel bus, updated on every commit, with no valid/ready qualifier.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every register reads zero and the readback pin is low.
- R2: A write frame is a direction bit of 0, then address bits A14..A0, then data bits D7..D0, each taken on a serial clock rise. The byte is committed to the addressed register only when the latch strobe rises. Before that rise the register bank does not change.
- R3: Each further 8 bits clocked in without a latch strobe push the earlier byte into the current address. The address then drops by one, so the bytes of one frame land at A, A-1, A-2, and so on.
- R4: The address decrement wraps from 0 to NUM_REGS-1.
- R5: A latch strobe that arrives before 24 bits have been received writes nothing. It restarts the bit count, so the next frame is decoded from its first bit.
- R6: A direction bit of 1 selects a read. After the 16th header bit, each serial clock fall puts the next bit of the addressed register on the readback pin, MSB first, so the master can sample it on the following rise. A read changes no register.
- R7: During a read, each completed byte is followed by the register at the next lower address.
- R8: While the enable input is high (inactive), serial clock and latch activity are ignored and the readback pin is low. Deasserting it in mid-frame discards the partial frame.
- R9: Writes to addresses at or above NUM_REGS change nothing, and reads from them return zero.
- R10: Bits clocked in after the last complete byte, fewer than 8, are discarded at the latch strobe. The last complete byte is still committed.
- R11: The readback pin returns low on the latch strobe rise that ends a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low interface enable (asynchronous) |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| sdi | input | 1 | Serial data in, taken on serial clock rise |
| sle | input | 1 | Latch strobe; its rise ends a frame |
| sdo | output | 1 | Readback data, updated after serial clock fall |
| regs_flat | output | NUM_REGS*8 | Register contents, register i at bits [8*i+7:8*i] |

## Verification
A serial edge at a pin acts at the third system clock edge after it: two synchronizer flops and one edge-detect flop. The register bus shows a commit right after that edge, and the readback pin shows a new bit after the same delay from a serial clock fall. The bench holds every serial clock and latch phase for four system clocks. It reads the readback pin at the falling system clock edge just before it raises the serial clock, and it checks the register bus six system clocks after a latch strobe falls, so each result is settled when it is read. Checks made before a latch strobe confirm that nothing lands early.

// File: rtl/scp_pkg.sv
package scp_pkg;

  // Frame field widths fixed by the serial format
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  // One write into the register bank
  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/scp_frame_engine.sv
module scp_frame_engine
  import scp_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              bit_val,
  input  logic              latch_rise,
  output wr_req_t           wr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rb_load,
  output logic              rb_shift,
  output logic              rb_clear
);

  localparam int HDR_BITS = 1 + ADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS + 1);
  localparam int BIDX_W   = $clog2(DATA_W);

  logic [ADDR_W-1:0] hdr_sh;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] byte_sh;
  logic [BIDX_W-1:0] bidx;
  logic [DATA_W-1:0] pend;
  logic              pend_vld;
  logic              is_rd;

  logic              data_phase;
  logic              byte_done;
  logic [DATA_W-1:0] next_byte;
  logic [ADDR_W-1:0] dec_addr;

  assign data_phase = (hdr_cnt == CNT_W'(HDR_BITS));
  assign byte_done  = bit_rise && data_phase && (bidx == BIDX_W'(DATA_W - 1));
  assign next_byte  = {byte_sh[DATA_W-2:0], bit_val};
  assign dec_addr   = (addr == '0) ? ADDR_W'(NUM_REGS - 1) : addr - ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_sh   <= '0;
      hdr_cnt  <= '0;
      addr     <= '0;
      byte_sh  <= '0;
      bidx     <= '0;
      pend     <= '0;
      pend_vld <= 1'b0;
      is_rd    <= 1'b0;
    end else if (!en_i || latch_rise) begin
      hdr_cnt  <= '0;
      bidx     <= '0;
      pend_vld <= 1'b0;
      is_rd    <= 1'b0;
    end else if (bit_rise) begin
      if (!data_phase) begin
        hdr_sh  <= {hdr_sh[ADDR_W-2:0], bit_val};
        hdr_cnt <= hdr_cnt + CNT_W'(1);
        if (hdr_cnt == CNT_W'(HDR_BITS - 1)) begin
          addr  <= {hdr_sh[ADDR_W-2:0], bit_val};
          is_rd <= hdr_sh[ADDR_W-1];
        end
      end else begin
        byte_sh <= next_byte;
        bidx    <= bidx + BIDX_W'(1);
        if (byte_done) begin
          if (is_rd) begin
            addr <= dec_addr;
          end else begin
            if (pend_vld) addr <= dec_addr;
            pend     <= next_byte;
            pend_vld <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    wr.en   = en_i && data_phase && !is_rd && pend_vld && (byte_done || latch_rise);
    wr.addr = addr;
    wr.data = pend;
  end

  assign cur_addr = addr;
  assign rb_load  = en_i && bit_fall && data_phase && is_rd && (bidx == '0);
  assign rb_shift = en_i && bit_fall && data_phase && is_rd && (bidx != '0);
  assign rb_clear = !en_i || latch_rise;

endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
  import scp_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  wr_req_t                    wr,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr.en) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr.addr == ADDR_W'(i)) mem[i] <= wr.data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = mem[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
    end
  endgenerate

endmodule

// File: rtl/scp_readback.sv
module scp_readback
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] load_data,
  output logic              sdo
);

  logic [DATA_W-1:0] sh;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      active <= 1'b0;
    end else if (clear) begin
      sh     <= '0;
      active <= 1'b0;
    end else if (load) begin
      sh     <= load_data;
      active <= 1'b1;
    end else if (shift) begin
      sh <= {sh[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = active && sh[DATA_W-1];

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scp_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_n,
  input  logic                       sclk,
  input  logic                       sdi,
  input  logic                       sle,
  output logic                       sdo,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  localparam int N_SYNC = 4;

  logic [N_SYNC-1:0] pins_sync;
  logic              sclk_q, sdi_q, sle_q, ce_q;
  logic              sclk_prev, sle_prev;
  logic              bit_rise, bit_fall, latch_rise;

  wr_req_t           wr_req;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rb_load, rb_shift, rb_clear;

  scp_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({~ce_n, sle, sdi, sclk}),
    .sync_o  (pins_sync)
  );

  assign {ce_q, sle_q, sdi_q, sclk_q} = pins_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      sle_prev  <= 1'b0;
    end else begin
      sclk_prev <= sclk_q;
      sle_prev  <= sle_q;
    end
  end

  assign bit_rise   = sclk_q && !sclk_prev;
  assign bit_fall   = !sclk_q && sclk_prev;
  assign latch_rise = sle_q && !sle_prev;

  scp_frame_engine #(.NUM_REGS(NUM_REGS)) engine_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (ce_q),
    .bit_rise   (bit_rise),
    .bit_fall   (bit_fall),
    .bit_val    (sdi_q),
    .latch_rise (latch_rise),
    .wr         (wr_req),
    .cur_addr   (cur_addr),
    .rb_load    (rb_load),
    .rb_shift   (rb_shift),
    .rb_clear   (rb_clear)
  );

  scp_regbank #(.NUM_REGS(NUM_REGS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_req),
    .rd_addr   (cur_addr),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

  scp_readback rb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (rb_clear),
    .load      (rb_load),
    .shift     (rb_shift),
    .load_data (rd_data),
    .sdo       (sdo)
  );

endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int NUM_REGS = 16,
  parameter int AW       = 15,
  parameter int DW       = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ce_q,
  input logic                   latch_rise,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic                   rb_load,
  input logic                   rb_clear,
  input logic [DW-1:0]          rd_data,
  input logic                   sdo,
  input logic [NUM_REGS*DW-1:0] regs_flat
);

  // R2: the bank moves only in the cycle after a write strobe
  a_r2_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  // R8: the disabled interface never drives readback
  a_r8_idle_sdo_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |=> !sdo);

  // R8: the disabled interface never changes the bank
  a_r8_idle_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |=> $stable(regs_flat));

  // R9: an address past the bank leaves every register alone
  a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_addr) >= NUM_REGS)) |=> $stable(regs_flat));

  // R6: a load puts the register MSB on the pin
  a_r6_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_load && !rb_clear) |=> (sdo == $past(rd_data[DW-1])));

  // R11: readback drops when the latch strobe rises
  a_r11_latch_drops_sdo: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise |=> !sdo);

endmodule

bind serial_cfg_port scp_checker #(
  .NUM_REGS (NUM_REGS),
  .AW       (scp_pkg::ADDR_W),
  .DW       (scp_pkg::DATA_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_q       (ce_q),
  .latch_rise (latch_rise),
  .wr_en      (wr_req.en),
  .wr_addr    (wr_req.addr),
  .rb_load    (rb_load),
  .rb_clear   (rb_clear),
  .rd_data    (rd_data),
  .sdo        (sdo),
  .regs_flat  (regs_flat)
);

// File: tb/serial_cfg_port_tb_top.sv
module serial_cfg_port_tb_top;

  localparam int NR   = 16;
  localparam int DW   = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sle = 1'b0;
  logic sdo;
  logic [NR*DW-1:0] regs_flat;

  always #10 clk = ~clk;

  serial_cfg_port #(.NUM_REGS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sclk(sclk),
    .sdi(sdi), .sle(sle), .sdo(sdo), .regs_flat(regs_flat)
  );

  typedef struct {
    int    kind;   // 0: readback pin, 1: register
    int    idx;
    int    exp;
    string req;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  logic [7:0] model [NR];

  // Monitor: pops expected items and compares them with the design
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        int act;
        it = sb.pop_front();
        if (it.kind == 0) act = int'(sdo);
        else act = int'(regs_flat[it.idx*DW +: DW]);
        checks++;
        if (act != it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                   it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic push_sdo(input int e, input string r);
    item_t it;
    it.kind = 0; it.idx = 0; it.exp = e; it.req = r;
    sb.push_back(it);
    -> chk_ev;
  endtask

  task automatic check_all(input string r);
    for (int i = 0; i < NR; i++) begin
      item_t it;
      it.kind = 1; it.idx = i; it.exp = int'(model[i]); it.req = r;
      sb.push_back(it);
    end
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, input bit chk, input int e, input string r);
    @(negedge clk);
    if (chk) push_sdo(e, r);
    sdi = b;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic header(input logic rw, input logic [14:0] a);
    clk_bit(rw, 1'b0, 0, "");
    for (int i = 14; i >= 0; i--) clk_bit(a[i], 1'b0, 0, "");
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) clk_bit(d[i], 1'b0, 0, "");
  endtask

  task automatic read_byte(input logic [7:0] e, input string r);
    for (int i = 7; i >= 0; i--) clk_bit(1'b0, 1'b1, int'(e[i]), r);
  endtask

  task automatic latch();
    @(negedge clk);
    sle = 1'b1;
    repeat (HALF) @(negedge clk);
    sle = 1'b0;
    repeat (HALF + 2) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    ce_n = 1'b0;
    repeat (6) @(negedge clk);

    // R1: reset state
    check_all("R1");
    push_sdo(0, "R1");
    @(negedge clk);

    // R2: single write, nothing before the latch strobe
    header(1'b0, 15'd5);
    send_byte(8'hA5);
    repeat (4) @(negedge clk);
    check_all("R2");
    latch();
    model[5] = 8'hA5;
    check_all("R2");

    // R3: streamed write lands at descending addresses
    header(1'b0, 15'd9);
    send_byte(8'h81);
    send_byte(8'hC2);
    send_byte(8'h93);
    latch();
    model[9] = 8'h81; model[8] = 8'hC2; model[7] = 8'h93;
    check_all("R3");

    // R4: address wraps from 0 to the top register
    header(1'b0, 15'd1);
    send_byte(8'h44);
    send_byte(8'h55);
    send_byte(8'h66);
    latch();
    model[1] = 8'h44; model[0] = 8'h55; model[15] = 8'h66;
    check_all("R4");

    // R5: early latch strobes are ignored and restart the count
    for (int i = 0; i < 10; i++) clk_bit(1'b1, 1'b0, 0, "");
    latch();
    header(1'b0, 15'd2);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, 1'b0, 0, "");
    latch();
    check_all("R5");
    header(1'b0, 15'd3);
    send_byte(8'h3C);
    latch();
    model[3] = 8'h3C;
    check_all("R5");

    // R10: trailing partial bits are discarded
    header(1'b0, 15'd12);
    send_byte(8'h81);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, 1'b0, 0, "");
    latch();
    model[12] = 8'h81;
    check_all("R10");

    // R6 / R7 / R11: streamed read
    header(1'b1, 15'd9);
    read_byte(8'h81, "R6");
    read_byte(8'hC2, "R7");
    @(negedge clk);
    push_sdo(1, "R7");          // next register (7, 0x93) already on pin
    latch();
    push_sdo(0, "R11");
    @(negedge clk);
    check_all("R6");

    // R9: out-of-range write and read
    header(1'b0, 15'd21);
    send_byte(8'hFF);
    latch();
    check_all("R9");
    header(1'b1, 15'd21);
    read_byte(8'h00, "R9");
    latch();
    header(1'b1, 15'd16);
    read_byte(8'h00, "R9");
    read_byte(8'h66, "R7");
    latch();

    // R8: disabled interface
    header(1'b1, 15'd5);
    clk_bit(1'b0, 1'b1, 1, "R6");
    @(negedge clk);
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
    push_sdo(0, "R8");
    @(negedge clk);
    header(1'b0, 15'd4);
    send_byte(8'h77);
    latch();
    check_all("R8");
    ce_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 12; i++) clk_bit(1'b1, 1'b0, 0, "");
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
    ce_n = 1'b0;
    repeat (6) @(negedge clk);
    header(1'b0, 15'd6);
    send_byte(8'h99);
    latch();
    model[6] = 8'h99;
    check_all("R8");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule